// File: doc/BRIEF.md
# Flash Fetch Buffer with Prefetch

This unit sits in front of a slow, word-wide, read-only non-volatile array and answers master reads from a small pool of four word buffers. A read whose word is already held is answered in the cycle it is presented. A read that finds nothing starts an array access. The word that comes back is written both to the most-recent-word buffer and to one slot of a round-robin group that keeps branch and loop targets. A configuration input adds one wait state to every array access.

When prefetch is switched on, one target slot is taken out of the round-robin group and becomes a single prefetch slot. While no master read is pending, the unit fetches the word that follows the last one served. A master read to any other address cancels this speculative access. If the master then asks for the prefetched word, the word moves into the most-recent slot and the next word is armed for prefetch. Switching prefetch on or off empties every buffer. The array is modelled inside the block: the word at byte address A reads as A XOR 0x5A5A0000.

Top module: `flash_fetch_accel`

## Requirements
- R1: A request whose word-aligned address is held in a valid buffer gets req_ready and rsp_valid in the same cycle, and rsp_data equals the array content {16'h5A5A, address}.
- R2: A request that misses every buffer and finds the array idle raises mem_rd_strobe with mem_rd_addr equal to the request address in that same cycle. The request is answered 2 cycles later with zero wait states and 3 cycles later with one wait state.
- R3: With prefetch off, three target slots are filled round-robin by demand misses. After four distinct misses A, B, C, D, the words B, C and D still hit and A misses.
- R4: With prefetch on, in the first cycle after a request is served with no request pending, one array read starts at the served address plus 4. No further read starts until another request is served. With prefetch off, idle cycles start no array read.
- R5: A request to a different address while a prefetch is in flight cancels the prefetch. A demand read for the new address starts in that same cycle, and the cancelled word is not held afterwards.
- R6: A request for the word in the prefetch slot is answered with no wait cycles, and the next word is armed for prefetch.
- R7: Serving any other address while prefetch is on empties the prefetch slot, so a later request for that word misses.
- R8: Any change of cfg_prefetch_en empties all buffers and cancels any array read. Requests in the change cycle are not answered.
- R9: A request for the address of an in-flight array read waits for that read and starts no second read. With one wait state, a request arriving one cycle after its prefetch started is answered 2 cycles later.
- R10: With prefetch on, only two target slots take part in round-robin replacement.
- R11: After reset, no buffer is valid, no read is in flight and nothing is armed. The first request misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wait1 | input | 1 | 1 selects one wait state per array access |
| cfg_prefetch_en | input | 1 | Enables the prefetch slot |
| req_valid | input | 1 | Master read request, held until accepted |
| req_addr | input | 16 | Byte address of the request (word aligned) |
| req_ready | output | 1 | Request accepted and answered this cycle |
| rsp_valid | output | 1 | Response data valid |
| rsp_data | output | 32 | Response word |
| mem_rd_strobe | output | 1 | An array read starts this cycle |
| mem_rd_addr | output | 16 | Byte address of the starting array read |

## Verification
The embedded assertions check on every cycle that every accepted response carries the array content for its address. They also check that no duplicate read starts for an address already in flight, that an idle-cycle read happens only with prefetch on, that flushing leaves every buffer empty, and that the round-robin pointer stays within the active group. The order of replacement, the exact latency of misses, promotions and cancelled prefetches, and the pause after a single prefetch depend on history. Only the bench's behavioural model and its scenario latencies can show those.

// File: rtl/ffb_pkg.sv
package ffb_pkg;
   typedef enum logic {
      KIND_DEMAND   = 1'b0,
      KIND_PREFETCH = 1'b1
   } rd_kind_e;
endpackage

// File: rtl/ffb_entry_store.sv
module ffb_entry_store #(
   parameter int unsigned NUM_BUF = 4,
   parameter int unsigned TW      = 14,
   parameter int unsigned DW      = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush,
   input  logic [TW-1:0]                lk_tag,
   input  logic [NUM_BUF-1:0]           set_en,
   input  logic [NUM_BUF-1:0]           clr_en,
   input  logic [NUM_BUF-1:0][TW-1:0]   set_tag,
   input  logic [NUM_BUF-1:0][DW-1:0]   set_dat,
   output logic [NUM_BUF-1:0]           hit_vec,
   output logic                         hit_any,
   output logic [DW-1:0]                hit_dat
);
   logic [NUM_BUF-1:0]          vld_q;
   logic [NUM_BUF-1:0][TW-1:0]  tag_q;
   logic [NUM_BUF-1:0][DW-1:0]  dat_q;

   generate
      if (NUM_BUF < 3) begin : g_bad_depth
         $error("ffb_entry_store needs at least three slots");
      end
      for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q[g] <= 1'b0;
               tag_q[g] <= '0;
               dat_q[g] <= '0;
            end else if (flush || clr_en[g]) begin
               vld_q[g] <= 1'b0;
            end else if (set_en[g]) begin
               vld_q[g] <= 1'b1;
               tag_q[g] <= set_tag[g];
               dat_q[g] <= set_dat[g];
            end
         end
         assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_tag);
      end
   endgenerate

   assign hit_any = |hit_vec;

   always_comb begin
      hit_dat = '0;
      for (int i = NUM_BUF - 1; i >= 0; i--) begin
         if (hit_vec[i]) hit_dat = dat_q[i];
      end
   end

   // R8
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld_q == '0));
endmodule

// File: rtl/ffb_rr_ptr.sv
module ffb_rr_ptr #(
   parameter int unsigned NUM_JMP = 3,
   localparam int unsigned PW = (NUM_JMP > 1) ? $clog2(NUM_JMP) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          adv,
   input  logic          shrink,
   output logic [PW-1:0] ptr
);
   logic [PW-1:0] ptr_q;
   logic [PW-1:0] last_idx;

   generate
      if (NUM_JMP < 2) begin : g_bad_jmp
         $error("ffb_rr_ptr needs at least two target slots");
      end
   endgenerate

   assign last_idx = shrink ? PW'(NUM_JMP - 2) : PW'(NUM_JMP - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ptr_q <= '0;
      else if (clear)      ptr_q <= '0;
      else if (adv)        ptr_q <= (ptr_q >= last_idx) ? '0 : ptr_q + 1'b1;
   end

   assign ptr = ptr_q;

   // R10
   rr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= last_idx);
endmodule

// File: rtl/ffb_nvm_model.sv
module ffb_nvm_model
   import ffb_pkg::*;
#(
   parameter int unsigned AW   = 16,
   parameter int unsigned DW   = 32,
   parameter logic [DW-1:0] SEED = 32'h5A5A_0000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  rd_kind_e      start_kind,
   input  logic [AW-1:0] start_addr,
   input  logic          wait1,
   input  logic          cancel,
   output logic          busy,
   output rd_kind_e      kind,
   output logic [AW-1:0] addr,
   output logic          done,
   output logic [DW-1:0] data
);
   logic          busy_q;
   logic          cnt_q;
   rd_kind_e      kind_q;
   logic [AW-1:0] addr_q;

   generate
      if (AW < 3 || DW < AW) begin : g_bad_width
         $error("ffb_nvm_model width parameters out of range");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= 1'b0;
         kind_q <= KIND_DEMAND;
         addr_q <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= wait1;
         kind_q <= start_kind;
         addr_q <= start_addr;
      end else if (cancel || done) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q  <= 1'b0;
      end
   end

   assign busy = busy_q;
   assign kind = kind_q;
   assign addr = addr_q;
   assign done = busy_q && !cnt_q;
   assign data = DW'(addr_q) ^ SEED;

   // R2
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   // R2
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt_q && !cancel && !start) |=> (busy && done));
endmodule

// File: rtl/flash_fetch_accel.sv
module flash_fetch_accel
   import ffb_pkg::*;
#(
   parameter int unsigned AW      = 16,
   parameter int unsigned DW      = 32,
   parameter int unsigned NUM_BUF = 4,
   parameter logic [DW-1:0] SEED  = 32'h5A5A_0000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wait1,
   input  logic          cfg_prefetch_en,
   input  logic          req_valid,
   input  logic [AW-1:0] req_addr,
   output logic          req_ready,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data,
   output logic          mem_rd_strobe,
   output logic [AW-1:0] mem_rd_addr
);
   localparam int unsigned TW      = AW - 2;
   localparam int unsigned NUM_JMP = NUM_BUF - 1;
   localparam int unsigned LV_SLOT = NUM_BUF - 1;
   localparam int unsigned PF_SLOT = NUM_BUF - 2;
   localparam int unsigned PW      = (NUM_JMP > 1) ? $clog2(NUM_JMP) : 1;

   generate
      if (NUM_BUF < 3) begin : g_bad_bufs
         $error("flash_fetch_accel needs at least three buffers");
      end
   endgenerate

   logic [TW-1:0]               req_tag;
   logic                        pe_q, flush;
   logic [NUM_BUF-1:0]          hit_vec, set_en, clr_en;
   logic [NUM_BUF-1:0][TW-1:0]  set_tag;
   logic [NUM_BUF-1:0][DW-1:0]  set_dat;
   logic                        hit_any;
   logic [DW-1:0]               hit_dat;
   logic                        nvm_busy, nvm_done, nvm_cancel, nvm_start;
   rd_kind_e                    nvm_kind, start_kind;
   logic [AW-1:0]               nvm_addr;
   logic [DW-1:0]               nvm_data;
   logic                        same_inflight, abort_pf, dem_start, pf_start, fill;
   logic                        arm_q;
   logic [TW-1:0]               arm_tag_q;
   logic [PW-1:0]               rr_ptr;
   logic                        rr_adv;

   assign req_tag = req_addr[AW-1:2];
   assign flush   = (cfg_prefetch_en != pe_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pe_q <= 1'b0;
      else        pe_q <= cfg_prefetch_en;
   end

   ffb_entry_store #(.NUM_BUF(NUM_BUF), .TW(TW), .DW(DW)) store_i (
      .clk(clk), .rst_n(rst_n), .flush(flush), .lk_tag(req_tag),
      .set_en(set_en), .clr_en(clr_en), .set_tag(set_tag), .set_dat(set_dat),
      .hit_vec(hit_vec), .hit_any(hit_any), .hit_dat(hit_dat)
   );

   ffb_rr_ptr #(.NUM_JMP(NUM_JMP)) rr_i (
      .clk(clk), .rst_n(rst_n), .clear(flush), .adv(rr_adv),
      .shrink(pe_q), .ptr(rr_ptr)
   );

   ffb_nvm_model #(.AW(AW), .DW(DW), .SEED(SEED)) nvm_i (
      .clk(clk), .rst_n(rst_n), .start(nvm_start), .start_kind(start_kind),
      .start_addr(mem_rd_addr), .wait1(cfg_wait1), .cancel(nvm_cancel),
      .busy(nvm_busy), .kind(nvm_kind), .addr(nvm_addr), .done(nvm_done),
      .data(nvm_data)
   );

   // request side
   assign req_ready     = req_valid && hit_any && !flush;
   assign rsp_valid     = req_ready;
   assign rsp_data      = hit_dat;

   // array scheduling: demand first, prefetch only on idle cycles
   assign same_inflight = nvm_busy && (nvm_addr[AW-1:2] == req_tag);
   assign abort_pf      = nvm_busy && (nvm_kind == KIND_PREFETCH) && req_valid
                          && !same_inflight && !flush;
   assign dem_start     = req_valid && !hit_any && !flush && !same_inflight
                          && (!nvm_busy || abort_pf);
   assign pf_start      = pe_q && !flush && arm_q && !req_valid && !nvm_busy;
   assign nvm_start     = dem_start || pf_start;
   assign nvm_cancel    = flush || abort_pf;
   assign start_kind    = dem_start ? KIND_DEMAND : KIND_PREFETCH;
   assign mem_rd_strobe = nvm_start;
   assign mem_rd_addr   = dem_start ? {req_tag, 2'b00} : {arm_tag_q, 2'b00};
   assign fill          = nvm_done && !nvm_cancel;

   // slot updates
   always_comb begin
      set_en  = '0;
      clr_en  = '0;
      set_tag = '0;
      set_dat = '0;
      rr_adv  = 1'b0;
      if (fill) begin
         if (nvm_kind == KIND_PREFETCH) begin
            set_en[PF_SLOT]  = 1'b1;
            set_tag[PF_SLOT] = nvm_addr[AW-1:2];
            set_dat[PF_SLOT] = nvm_data;
         end else begin
            set_en[LV_SLOT]  = 1'b1;
            set_tag[LV_SLOT] = nvm_addr[AW-1:2];
            set_dat[LV_SLOT] = nvm_data;
            set_en[rr_ptr]   = 1'b1;
            set_tag[rr_ptr]  = nvm_addr[AW-1:2];
            set_dat[rr_ptr]  = nvm_data;
            rr_adv           = 1'b1;
         end
      end
      if (req_ready) begin
         set_en[LV_SLOT]  = 1'b1;
         set_tag[LV_SLOT] = req_tag;
         set_dat[LV_SLOT] = hit_dat;
         if (pe_q) clr_en[PF_SLOT] = 1'b1;
      end
   end

   // prefetch arming: one target, consumed when the read starts
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q     <= 1'b0;
         arm_tag_q <= '0;
      end else if (flush) begin
         arm_q     <= 1'b0;
      end else if (req_ready) begin
         arm_q     <= 1'b1;
         arm_tag_q <= req_tag + 1'b1;
      end else if (pf_start) begin
         arm_q     <= 1'b0;
      end
   end

   // R1
   hit_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (rsp_data == (DW'({req_tag, 2'b00}) ^ SEED)));
   // R9
   no_dup_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && nvm_busy && (nvm_addr[AW-1:2] == req_tag)) |-> !mem_rd_strobe);
   // R4
   idle_read_pf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_strobe && !req_valid) |-> cfg_prefetch_en);
endmodule

// File: tb/flash_fetch_accel_tb_top.sv
`timescale 1ns/1ps
module flash_fetch_accel_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wait1 = 1'b0;
   logic        cfg_prefetch_en = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_addr = '0;
   logic        req_ready, rsp_valid, mem_rd_strobe;
   logic [31:0] rsp_data;
   logic [15:0] mem_rd_addr;

   int compared = 0;
   int mismatched = 0;
   int strobes = 0;

   always #2 clk = ~clk;

   flash_fetch_accel dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wait1(cfg_wait1),
      .cfg_prefetch_en(cfg_prefetch_en), .req_valid(req_valid),
      .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .mem_rd_strobe(mem_rd_strobe),
      .mem_rd_addr(mem_rd_addr)
   );

   // behavioural reference: -1 marks an empty slot / idle engine / nothing armed
   int  tgt[3];
   int  last_w, pf_w, nxt, left_c, eng_a, arm_a;
   bit  eng_spec, pe_prev;

   function automatic int content(int a);
      return (a & 16'hFFFF) ^ 32'h5A5A_0000;
   endfunction

   function automatic bit held(int a);
      bit r = (a == last_w) || (a == pf_w);
      foreach (tgt[k]) if (tgt[k] == a) r = 1'b1;
      return r;
   endfunction

   task automatic model_reset();
      foreach (tgt[k]) tgt[k] = -1;
      last_w = -1; pf_w = -1; nxt = 0; left_c = -1; eng_a = 0;
      arm_a = -1; eng_spec = 0; pe_prev = 0;
   endtask

   task automatic check(string rq, int got, int exp);
      compared++;
      if (got != exp) begin
         mismatched++;
         $display("FAIL %s: got %0h expected %0h at %0t", rq, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         bit fl, hit, same, abort, dst, pst, done;
         int a;
         a    = int'(req_addr);
         fl   = (cfg_prefetch_en != pe_prev);
         hit  = req_valid && held(a) && !fl;
         same = (left_c >= 0) && (eng_a == a);
         abort = (left_c >= 0) && eng_spec && req_valid && !same && !fl;
         dst  = req_valid && !held(a) && !fl && !same && (left_c < 0 || abort);
         pst  = pe_prev && !fl && (arm_a >= 0) && !req_valid && (left_c < 0);
         if (mem_rd_strobe) strobes++;
         check("R2 ready", int'(req_ready), int'(hit));
         if (hit) check("R1 data", int'(rsp_data), content(a));
         check("R4 strobe", int'(mem_rd_strobe), int'(dst || pst));
         if (dst || pst) check("R4 read addr", int'(mem_rd_addr), dst ? a : arm_a);
         if (fl) begin
            foreach (tgt[k]) tgt[k] = -1;
            last_w = -1; pf_w = -1; nxt = 0; left_c = -1; arm_a = -1;
            pe_prev = cfg_prefetch_en;
         end else begin
            done = (left_c == 0) && !abort;
            if (done) begin
               if (eng_spec) pf_w = eng_a;
               else begin
                  last_w = eng_a; tgt[nxt] = eng_a;
                  nxt = (nxt + 1) % (pe_prev ? 2 : 3);
               end
            end
            if (dst) begin left_c = int'(cfg_wait1); eng_a = a; eng_spec = 0; end
            else if (pst) begin left_c = int'(cfg_wait1); eng_a = arm_a; eng_spec = 1; end
            else if (abort || left_c == 0) left_c = -1;
            else if (left_c > 0) left_c--;
            if (hit) begin
               last_w = a;
               if (pe_prev) pf_w = -1;
               arm_a = (a + 4) & 16'hFFFF;
            end else if (pst) arm_a = -1;
         end
      end
   end

   // drive at posedge+1; returns cycles waited before acceptance
   task automatic fetch(int a, output int lat);
      lat = 0;
      req_valid = 1'b1;
      req_addr  = 16'(a);
      forever begin
         @(negedge clk);
         if (req_ready) break;
         lat++;
         @(posedge clk); #1;
      end
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic fl(string rq, int a, int exp_lat);
      int l;
      fetch(a, l);
      check(rq, l, exp_lat);
   endtask

   initial begin
      #100000;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      int s0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R11 reset ready", int'(req_ready), 0);
      check("R11 reset strobe", int'(mem_rd_strobe), 0);
      @(posedge clk); #1;
      // prefetch off, zero wait states
      fl("R11 cold miss", 'h100, 2);
      fl("R1 hit last word", 'h100, 0);
      fl("R2 miss ws0", 'h200, 2);
      fl("R2 miss ws0", 'h300, 2);
      fl("R3 fourth target", 'h400, 2);
      fl("R3 kept target", 'h200, 0);
      fl("R3 kept target", 'h300, 0);
      fl("R3 kept target", 'h400, 0);
      fl("R3 evicted target", 'h100, 2);
      s0 = strobes;
      idle(5);
      check("R4 no idle read when off", strobes - s0, 0);
      cfg_wait1 = 1'b1;
      fl("R2 miss ws1", 'h500, 3);
      // prefetch on
      cfg_prefetch_en = 1'b1;
      idle(1);
      fl("R8 flushed on enable", 'h200, 3);
      fl("R4 no prefetch while busy", 'h600, 3);
      idle(3);
      fl("R6 prefetched word", 'h604, 0);
      s0 = strobes;
      idle(6);
      check("R4 single prefetch then pause", strobes - s0, 1);
      fl("R6 promoted again", 'h608, 0);
      idle(4);
      fl("R7 target hit", 'h200, 0);
      fl("R7 prefetch discarded", 'h60C, 3);
      s0 = strobes;
      idle(1);
      fl("R5 abort and demand", 'h700, 3);
      check("R5 reads issued", strobes - s0, 2);
      fl("R5 aborted word absent", 'h610, 3);
      s0 = strobes;
      idle(1);
      fl("R9 wait on inflight", 'h614, 2);
      check("R9 no second read", strobes - s0, 1);
      fl("R10 two-slot hit", 'h700, 0);
      fl("R10 replace", 'h60C, 3);
      fl("R10 round-robin eviction", 'h700, 3);
      cfg_prefetch_en = 1'b0;
      idle(1);
      fl("R8 flushed on disable", 'h700, 3);
      idle(2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule